// File: doc/BRIEF.md
# Bus Master Write Parity Error Reporter

This block decides what a bus master does when a target flags a data parity error against one of the master's outbound writes. It watches a sampled parity-error strobe from the target, the kind of write in flight (an ordinary posted or non-posted write, or a message-signaled-interrupt write) and the bus mode (conventional or PCI-X). From a set of configuration bits it decides which sticky status bits to record, which interrupt-status bits to raise and whether to escalate by pulsing an active-low system-error line.

It also steers the write engine. An ordinary write that hits an error keeps pushing its remaining data so that the outbound queue empties. Such a write never reports a master completion, and it asks for a reissue if the target disconnects part way through. A message-signaled-interrupt write finishes normally, and its error actions are deferred until it has completed. Software clears the recorded bits by writing ones to two clear ports.

Top module: `wr_perr_reporter`

## Requirements
- R1: A parity-error event (status bit 0 of `stat`) is recorded only while `cfg_perr_resp` is 1. With `cfg_perr_resp` at 0, a parity error changes no status bit and no interrupt-status bit, and it does not pulse `serr_n`.
- R2: When the parity-error status bit is set, interrupt-status bit 0 of `istat` is set as well, unless `cfg_mpe_mask` is 1. With the mask at 1, that bit stays as it was.
- R3: For an ordinary write (`is_msi`=0), a recorded parity error escalates to system error only when `pcix_mode`=1, `cfg_serr_en`=1 and `cfg_recover_en`=0. Its status bits update on the clock edge that samples the strobe.
- R4: For a message-signaled-interrupt write (`is_msi`=1), a recorded parity error escalates whenever `cfg_serr_en`=1, whatever the values of `pcix_mode` and `cfg_recover_en`. All of its error actions take effect on the edge that samples `xfer_last`, not on the edge that samples the strobe.
- R5: Each escalation drives `serr_n` low for exactly the one cycle after the edge that records it.
- R6: Each escalation sets status bit 1 of `stat`. It also sets interrupt-status bit 1 of `istat` unless `cfg_serr_mask` is 1.
- R7: Each escalation sets interrupt-status bit 2 of `istat` when `cfg_serr_det_ie` is 1, and leaves that bit alone when the enable is 0.
- R8: An error on an ordinary write raises `drain_cont` from the next cycle until the cycle after `xfer_last`. That transaction gives no `master_cmpl` pulse, whatever the value of `cfg_perr_resp`.
- R9: A `tgt_disc` during an errored ordinary write gives a one-cycle `reissue_req` pulse. A disconnect on an error-free write gives no pulse.
- R10: `master_cmpl` pulses for one cycle after `xfer_last` for every message-signaled-interrupt write, including one that saw an error, and for every ordinary write that saw no error.
- R11: All bits of `stat` and `istat` reset to 0 and are sticky. Writing a 1 through the matching clear port (`stat_clr_*` or `istat_clr_*`) clears a bit. When a set and a clear hit the same bit in the same cycle, the set wins.
- R12: `irq` is 1 exactly when any bit of `istat` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_strobe | input | 1 | Target parity error sampled active this cycle |
| is_msi | input | 1 | 1 = message-signaled-interrupt write, 0 = ordinary write |
| pcix_mode | input | 1 | 1 = PCI-X mode, 0 = conventional mode |
| xfer_last | input | 1 | Final data phase of the current write accepted |
| tgt_disc | input | 1 | Target disconnected the current write |
| cfg_perr_resp | input | 1 | Parity-error response enable |
| cfg_serr_en | input | 1 | System-error enable |
| cfg_recover_en | input | 1 | Uncorrectable-error recover enable |
| cfg_mpe_mask | input | 1 | Interrupt mask for the parity-error bit |
| cfg_serr_mask | input | 1 | Interrupt mask for the system-error-asserted bit |
| cfg_serr_det_ie | input | 1 | Interrupt enable for the system-error-detected bit |
| stat_clr_wr | input | 1 | Write strobe for clearing status bits |
| stat_clr_data | input | 2 | Ones select the status bits to clear |
| istat_clr_wr | input | 1 | Write strobe for clearing interrupt-status bits |
| istat_clr_data | input | 3 | Ones select the interrupt-status bits to clear |
| serr_n | output | 1 | Active-low system-error pulse |
| stat | output | 2 | Sticky status: bit 0 parity error, bit 1 system error asserted |
| istat | output | 3 | Interrupt status: bit 0 parity error, bit 1 system error asserted, bit 2 system error detected |
| irq | output | 1 | Interrupt request |
| drain_cont | output | 1 | Keep draining the queue without completing |
| master_cmpl | output | 1 | Master completion pulse |
| reissue_req | output | 1 | Request to reissue the disconnected write |

## Verification
Two things can meet on the same status bit in one cycle: a new parity-error event that sets the bit, and a write-one-to-clear from software aimed at it. The bench records the bit once, then raises a new error strobe on the very edge that carries the clear. It expects the bit to read 1 afterwards. It then repeats the clear with no error present and expects 0. A second collision puts an error strobe and `xfer_last` on the same edge of an ordinary write. The bench expects no completion pulse and `drain_cont` already low.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
    localparam int STAT_W  = 2;
    localparam int ISTAT_W = 3;

    localparam int ST_MPE  = 0;
    localparam int ST_SERR = 1;

    localparam int IS_MPE  = 0;
    localparam int IS_SERR = 1;
    localparam int IS_DET  = 2;

    typedef enum logic {
        WK_ORDINARY = 1'b0,
        WK_MSI      = 1'b1
    } wr_kind_e;

    typedef struct packed {
        logic pend;
    } ev_state_t;

    typedef struct packed {
        logic [STAT_W-1:0]  stat;
        logic [ISTAT_W-1:0] istat;
        logic               serr_low;
    } st_state_t;

    typedef struct packed {
        logic drain;
        logic cmpl;
        logic reissue;
    } dr_state_t;
endpackage

// File: rtl/wpr_event.sv
module wpr_event
    import wpr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err_strobe,
    input  logic is_msi,
    input  logic xfer_last,
    input  logic pcix_mode,
    input  logic cfg_perr_resp,
    input  logic cfg_serr_en,
    input  logic cfg_recover_en,
    output logic mpe_ev,
    output logic serr_ev
);
    ev_state_t st_d, st_q;
    logic      msi_err;
    logic      ord_err;
    logic      escal_ok;

    always_comb begin
        st_d     = st_q;
        msi_err  = err_strobe & (wr_kind_e'(is_msi) == WK_MSI) & cfg_perr_resp;
        ord_err  = err_strobe & (wr_kind_e'(is_msi) == WK_ORDINARY) & cfg_perr_resp;
        if (xfer_last)
            st_d.pend = 1'b0;
        else if (msi_err)
            st_d.pend = 1'b1;
        mpe_ev   = ord_err | (xfer_last & is_msi & (st_q.pend | msi_err));
        escal_ok = is_msi | (pcix_mode & ~cfg_recover_en);
        serr_ev  = mpe_ev & cfg_serr_en & escal_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    // R1
    no_resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_perr_resp && !st_q.pend) |-> (!mpe_ev && !serr_ev));

    // R3
    ord_escal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serr_ev && !is_msi) |-> (pcix_mode && cfg_serr_en && !cfg_recover_en));

    // R4
    msi_deferred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_msi && !xfer_last) |-> !mpe_ev);
endmodule

// File: rtl/wpr_status.sv
module wpr_status
    import wpr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mpe_ev,
    input  logic               serr_ev,
    input  logic               cfg_mpe_mask,
    input  logic               cfg_serr_mask,
    input  logic               cfg_serr_det_ie,
    input  logic               stat_clr_wr,
    input  logic [STAT_W-1:0]  stat_clr_data,
    input  logic               istat_clr_wr,
    input  logic [ISTAT_W-1:0] istat_clr_data,
    output logic [STAT_W-1:0]  stat,
    output logic [ISTAT_W-1:0] istat,
    output logic               serr_n,
    output logic               irq
);
    st_state_t          st_d, st_q;
    logic [STAT_W-1:0]  stat_set;
    logic [ISTAT_W-1:0] istat_set;

    always_comb begin
        st_d      = st_q;
        stat_set  = '0;
        istat_set = '0;

        stat_set[ST_MPE]   = mpe_ev;
        stat_set[ST_SERR]  = serr_ev;
        istat_set[IS_MPE]  = mpe_ev & ~cfg_mpe_mask;
        istat_set[IS_SERR] = serr_ev & ~cfg_serr_mask;
        istat_set[IS_DET]  = serr_ev & cfg_serr_det_ie;

        if (stat_clr_wr)
            st_d.stat = st_d.stat & ~stat_clr_data;
        if (istat_clr_wr)
            st_d.istat = st_d.istat & ~istat_clr_data;

        st_d.stat     = st_d.stat | stat_set;
        st_d.istat    = st_d.istat | istat_set;
        st_d.serr_low = serr_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign stat   = st_q.stat;
    assign istat  = st_q.istat;
    assign serr_n = ~st_q.serr_low;
    assign irq    = |st_q.istat;

    // R5
    serr_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> stat[ST_SERR]);

    // R2
    mpe_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mpe_ev && cfg_mpe_mask && !istat[IS_MPE]) |=> !istat[IS_MPE]);

    // R11
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[ST_MPE] && !(stat_clr_wr && stat_clr_data[ST_MPE])) |=> stat[ST_MPE]);

    // R11
    set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mpe_ev |=> stat[ST_MPE]);
endmodule

// File: rtl/wpr_drain.sv
module wpr_drain
    import wpr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err_strobe,
    input  logic is_msi,
    input  logic xfer_last,
    input  logic tgt_disc,
    output logic drain_cont,
    output logic master_cmpl,
    output logic reissue_req
);
    dr_state_t st_d, st_q;
    logic      ord_err;
    logic      errored;

    always_comb begin
        st_d       = st_q;
        ord_err    = err_strobe & (wr_kind_e'(is_msi) == WK_ORDINARY);
        errored    = st_q.drain | ord_err;
        st_d.drain   = errored & ~xfer_last;
        st_d.cmpl    = xfer_last & (is_msi | ~errored);
        st_d.reissue = tgt_disc & ~is_msi & errored;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign drain_cont  = st_q.drain;
    assign master_cmpl = st_q.cmpl;
    assign reissue_req = st_q.reissue;

    // R8
    drain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_strobe && !is_msi && !xfer_last) |=> drain_cont);

    // R8
    no_cmpl_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_cont && !is_msi) |=> !master_cmpl);

    // R10
    msi_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_last && is_msi) |=> master_cmpl);
endmodule

// File: rtl/wr_perr_reporter.sv
module wr_perr_reporter
    import wpr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               err_strobe,
    input  logic               is_msi,
    input  logic               pcix_mode,
    input  logic               xfer_last,
    input  logic               tgt_disc,
    input  logic               cfg_perr_resp,
    input  logic               cfg_serr_en,
    input  logic               cfg_recover_en,
    input  logic               cfg_mpe_mask,
    input  logic               cfg_serr_mask,
    input  logic               cfg_serr_det_ie,
    input  logic               stat_clr_wr,
    input  logic [STAT_W-1:0]  stat_clr_data,
    input  logic               istat_clr_wr,
    input  logic [ISTAT_W-1:0] istat_clr_data,
    output logic               serr_n,
    output logic [STAT_W-1:0]  stat,
    output logic [ISTAT_W-1:0] istat,
    output logic               irq,
    output logic               drain_cont,
    output logic               master_cmpl,
    output logic               reissue_req
);
    logic mpe_ev;
    logic serr_ev;

    wpr_event u_event (
        .clk            (clk),
        .rst_n          (rst_n),
        .err_strobe     (err_strobe),
        .is_msi         (is_msi),
        .xfer_last      (xfer_last),
        .pcix_mode      (pcix_mode),
        .cfg_perr_resp  (cfg_perr_resp),
        .cfg_serr_en    (cfg_serr_en),
        .cfg_recover_en (cfg_recover_en),
        .mpe_ev         (mpe_ev),
        .serr_ev        (serr_ev)
    );

    wpr_status u_status (
        .clk             (clk),
        .rst_n           (rst_n),
        .mpe_ev          (mpe_ev),
        .serr_ev         (serr_ev),
        .cfg_mpe_mask    (cfg_mpe_mask),
        .cfg_serr_mask   (cfg_serr_mask),
        .cfg_serr_det_ie (cfg_serr_det_ie),
        .stat_clr_wr     (stat_clr_wr),
        .stat_clr_data   (stat_clr_data),
        .istat_clr_wr    (istat_clr_wr),
        .istat_clr_data  (istat_clr_data),
        .stat            (stat),
        .istat           (istat),
        .serr_n          (serr_n),
        .irq             (irq)
    );

    wpr_drain u_drain (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_strobe  (err_strobe),
        .is_msi      (is_msi),
        .xfer_last   (xfer_last),
        .tgt_disc    (tgt_disc),
        .drain_cont  (drain_cont),
        .master_cmpl (master_cmpl),
        .reissue_req (reissue_req)
    );

    // R12
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (istat != '0) |-> irq);

    // R6
    serr_stat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_ev |=> (!serr_n && stat[ST_SERR]));
endmodule

// File: tb/wr_perr_reporter_test.sv
module wr_perr_reporter_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       err_strobe, is_msi, pcix_mode, xfer_last, tgt_disc;
    logic       cfg_perr_resp, cfg_serr_en, cfg_recover_en;
    logic       cfg_mpe_mask, cfg_serr_mask, cfg_serr_det_ie;
    logic       stat_clr_wr, istat_clr_wr;
    logic [1:0] stat_clr_data;
    logic [2:0] istat_clr_data;
    logic       serr_n, irq, drain_cont, master_cmpl, reissue_req;
    logic [1:0] stat;
    logic [2:0] istat;

    int nchk  = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    wr_perr_reporter uut (
        .clk(clk), .rst_n(rst_n), .err_strobe(err_strobe), .is_msi(is_msi),
        .pcix_mode(pcix_mode), .xfer_last(xfer_last), .tgt_disc(tgt_disc),
        .cfg_perr_resp(cfg_perr_resp), .cfg_serr_en(cfg_serr_en),
        .cfg_recover_en(cfg_recover_en), .cfg_mpe_mask(cfg_mpe_mask),
        .cfg_serr_mask(cfg_serr_mask), .cfg_serr_det_ie(cfg_serr_det_ie),
        .stat_clr_wr(stat_clr_wr), .stat_clr_data(stat_clr_data),
        .istat_clr_wr(istat_clr_wr), .istat_clr_data(istat_clr_data),
        .serr_n(serr_n), .stat(stat), .istat(istat), .irq(irq),
        .drain_cont(drain_cont), .master_cmpl(master_cmpl), .reissue_req(reissue_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic cfg(input logic msi, input logic px, input logic resp, input logic sen,
                       input logic rec, input logic mm, input logic sm, input logic ie);
        is_msi = msi; pcix_mode = px; cfg_perr_resp = resp; cfg_serr_en = sen;
        cfg_recover_en = rec; cfg_mpe_mask = mm; cfg_serr_mask = sm; cfg_serr_det_ie = ie;
    endtask

    task automatic pulse_err();
        err_strobe = 1'b1; tick(); err_strobe = 1'b0;
    endtask

    task automatic pulse_last();
        xfer_last = 1'b1; tick(); xfer_last = 1'b0;
    endtask

    task automatic wipe();
        stat_clr_wr = 1'b1; stat_clr_data = 2'b11;
        istat_clr_wr = 1'b1; istat_clr_data = 3'b111;
        tick();
        stat_clr_wr = 1'b0; istat_clr_wr = 1'b0;
        stat_clr_data = '0; istat_clr_data = '0;
    endtask

    task automatic t_reset();
        chk("R11 reset stat", 8'(stat), 8'h0);
        chk("R11 reset istat", 8'(istat), 8'h0);
        chk("R5 reset serr_n", 8'(serr_n), 8'h1);
        chk("R12 reset irq", 8'(irq), 8'h0);
        chk("R8 reset drain", 8'(drain_cont), 8'h0);
    endtask

    task automatic t_ord_pcix_full();
        cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        pulse_err();
        chk("R3 R5 serr low", 8'(serr_n), 8'h0);
        chk("R1 R6 stat", 8'(stat), 8'h3);
        chk("R2 R6 R7 istat", 8'(istat), 8'h7);
        chk("R12 irq", 8'(irq), 8'h1);
        chk("R8 drain", 8'(drain_cont), 8'h1);
        tick();
        chk("R5 serr one cycle", 8'(serr_n), 8'h1);
        tgt_disc = 1'b1; tick(); tgt_disc = 1'b0;
        chk("R9 reissue", 8'(reissue_req), 8'h1);
        tick();
        chk("R9 reissue one cycle", 8'(reissue_req), 8'h0);
        pulse_last();
        chk("R8 no cmpl", 8'(master_cmpl), 8'h0);
        chk("R8 drain ends", 8'(drain_cont), 8'h0);
        wipe();
        chk("R11 cleared stat", 8'(stat), 8'h0);
        chk("R11 cleared istat", 8'(istat), 8'h0);
        chk("R12 irq low", 8'(irq), 8'h0);
    endtask

    task automatic t_ord_conv();
        cfg(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        pulse_err();
        chk("R3 conv no serr", 8'(serr_n), 8'h1);
        chk("R3 conv stat", 8'(stat), 8'h1);
        chk("R3 conv istat", 8'(istat), 8'h1);
        pulse_last();
        wipe();
    endtask

    task automatic t_ord_recover();
        cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        pulse_err();
        chk("R3 recover no serr", 8'(serr_n), 8'h1);
        chk("R3 recover stat", 8'(stat), 8'h1);
        pulse_last();
        wipe();
    endtask

    task automatic t_no_resp();
        cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        pulse_err();
        chk("R1 no stat", 8'(stat), 8'h0);
        chk("R1 no istat", 8'(istat), 8'h0);
        chk("R1 no serr", 8'(serr_n), 8'h1);
        chk("R8 drain without resp", 8'(drain_cont), 8'h1);
        pulse_last();
        chk("R8 no cmpl without resp", 8'(master_cmpl), 8'h0);
    endtask

    task automatic t_masks();
        cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        pulse_err();
        chk("R6 masked serr low", 8'(serr_n), 8'h0);
        chk("R6 masked stat", 8'(stat), 8'h3);
        chk("R2 R6 R7 masked istat", 8'(istat), 8'h0);
        chk("R12 masked irq", 8'(irq), 8'h0);
        pulse_last();
        wipe();
    endtask

    task automatic t_msi_serr();
        cfg(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        pulse_err();
        chk("R4 deferred stat", 8'(stat), 8'h0);
        chk("R4 deferred serr", 8'(serr_n), 8'h1);
        chk("R10 msi no drain", 8'(drain_cont), 8'h0);
        pulse_last();
        chk("R10 msi cmpl", 8'(master_cmpl), 8'h1);
        chk("R4 msi stat", 8'(stat), 8'h3);
        chk("R4 msi istat", 8'(istat), 8'h7);
        chk("R4 msi serr", 8'(serr_n), 8'h0);
        tick();
        chk("R5 msi serr one cycle", 8'(serr_n), 8'h1);
        chk("R10 cmpl one cycle", 8'(master_cmpl), 8'h0);
        wipe();
    endtask

    task automatic t_msi_noserr();
        cfg(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        pulse_err();
        pulse_last();
        chk("R4 msi serr disabled", 8'(serr_n), 8'h1);
        chk("R4 msi stat only mpe", 8'(stat), 8'h1);
        chk("R7 no det without serr", 8'(istat), 8'h1);
        wipe();
    endtask

    task automatic t_set_vs_clear();
        cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        pulse_err();
        chk("R11 set", 8'(stat), 8'h1);
        err_strobe = 1'b1; stat_clr_wr = 1'b1; stat_clr_data = 2'b01;
        tick();
        err_strobe = 1'b0; stat_clr_wr = 1'b0; stat_clr_data = '0;
        chk("R11 set beats clear", 8'(stat), 8'h1);
        stat_clr_wr = 1'b1; stat_clr_data = 2'b10; tick(); stat_clr_wr = 1'b0;
        chk("R11 other bit clear keeps", 8'(stat), 8'h1);
        stat_clr_wr = 1'b1; stat_clr_data = 2'b01; tick(); stat_clr_wr = 1'b0;
        stat_clr_data = '0;
        chk("R11 clear alone", 8'(stat), 8'h0);
        chk("R12 irq with istat", 8'(irq), 8'h1);
        pulse_last();
        wipe();
    endtask

    task automatic t_complete_cases();
        cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        pulse_last();
        chk("R10 clean ordinary cmpl", 8'(master_cmpl), 8'h1);
        tgt_disc = 1'b1; tick(); tgt_disc = 1'b0;
        chk("R9 clean disc no reissue", 8'(reissue_req), 8'h0);
        err_strobe = 1'b1; xfer_last = 1'b1; tick();
        err_strobe = 1'b0; xfer_last = 1'b0;
        chk("R8 err on last no cmpl", 8'(master_cmpl), 8'h0);
        chk("R8 err on last no drain", 8'(drain_cont), 8'h0);
        wipe();
    endtask

    initial begin
        #(8 * 100000);
        nfail++;
        $display("FAIL watchdog R1..R12 actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        err_strobe = 0; xfer_last = 0; tgt_disc = 0;
        stat_clr_wr = 0; istat_clr_wr = 0; stat_clr_data = '0; istat_clr_data = '0;
        cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_ord_pcix_full();
        t_ord_conv();
        t_ord_recover();
        t_no_resp();
        t_masks();
        t_msi_serr();
        t_msi_noserr();
        t_set_vs_clear();
        t_complete_cases();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule